// File: doc/BRIEF.md
# Punctured Turbo Convolutional Encoder

This block turns a frame of information bits into a turbo-coded serial symbol stream. Two identical recursive systematic convolutional encoders run side by side. The first reads the frame in natural order. The second reads the same bits in a permuted order. An external interleaver supplies that order combinationally: the block presents a natural index and receives the permuted address back in the same cycle. The frame is first written bit by bit into an internal buffer through a valid/ready handshake. Only after the last bit has been written does the block stream out its symbols. The input stays closed until the frame's final symbol leaves.

A mode bit is captured together with the last information bit. It selects one of two forms of the stream. The full form sends the systematic bit and both parity bits for every index, for rate 1/3. The punctured form sends the systematic bit plus exactly one parity bit, and the two encoders take turns by index parity, for rate 1/2. After the data, each trellis is driven back to the all-zero state with two tail steps. The tail input of each step is the encoder's own feedback value. The tail symbols are never punctured, and a last flag marks the final one.

Top module: `turbo_punct_enc`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of loading, inReady is 1 and outValid and outLast are 0. The next frame is then loaded starting from index 0.
- R2: In the load phase, one information bit is taken on each rising edge where inValid and inReady are both 1, and the load ends with the FRAME_LEN-th bit. inReady is 0 from the edge that takes that bit until the edge that presents the frame's last symbol. It is 1 while outLast is 1.
- R3: Each component encoder holds two state bits s1 and s2, both zero at frame start. For input u it forms a = u ^ s1 ^ s2 and parity = a ^ s2, and then shifts to s1 = a, s2 = old s1.
- R4: While data symbols for index i are emitted, ilvAddr equals i. Encoder 2 is fed the buffered bit at address ilvPerm, and encoder 1 is fed the bit at address i.
- R5: In full mode (rateHalf = 0), index i emits its systematic bit, then encoder-1 parity, then encoder-2 parity, for i = 0 to FRAME_LEN-1. Encoder 2's systematic bit is never sent.
- R6: In punctured mode (rateHalf = 1), an even index (0 counts as even) emits its systematic bit and then encoder-2 parity. An odd index emits its systematic bit and then encoder-1 parity.
- R7: rateHalf is sampled on the edge that takes the last information bit. Changing it afterwards has no effect on the current frame.
- R8: After the data, encoder 1 takes two tail steps and then encoder 2 takes two. Each step emits the tail input (s1 ^ s2) and then the tail parity (s2), in both modes. Each trellis ends in the zero state.
- R9: A frame yields 3*FRAME_LEN+8 symbols in full mode and 2*FRAME_LEN+8 in punctured mode. outLast is 1 only together with the final tail symbol.
- R10: The first symbol appears on the second rising edge after the edge that takes the last information bit. Symbols then follow on consecutive cycles, with no gap, up to the last one.
- R11: inValid and inBit are ignored while a frame is being encoded. The output stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An information bit is offered |
| inReady | output | 1 | The block accepts information bits |
| inBit | input | 1 | Information bit value |
| rateHalf | input | 1 | 1 selects punctured rate-1/2 output; captured with the last bit |
| ilvAddr | output | IDX_W | Natural index currently being encoded |
| ilvPerm | input | IDX_W | Permuted address for ilvAddr, from the external interleaver |
| outValid | output | 1 | outBit holds a symbol |
| outBit | output | 1 | Serial coded symbol |
| outLast | output | 1 | Final tail symbol of the frame |

## Verification
The checker watches the stream's framing on every cycle. The last flag comes only with a valid symbol and is followed by an idle cycle. No symbol leaves while the block is loading, except the last one. A frame emits without gaps, and the input reopens exactly when the last symbol appears. The symbol values can only be shown by the bench's scenarios, which compare the stream against an independent encoder model. These scenarios cover the puncturing pattern by index parity, the permuted feed of encoder 2, and state-dependent tails such as a lone one at the final index. They also show that mode changes and input activity after loading are ignored, and that a reset in the middle of loading recovers cleanly.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_DATA,
    PH_TAIL1,
    PH_TAIL2
  } phase_e;

  typedef enum logic [2:0] {
    SEL_SYS,
    SEL_PAR1,
    SEL_PAR2,
    SEL_TSYS1,
    SEL_TPAR1,
    SEL_TSYS2,
    SEL_TPAR2
  } symSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    logic    clrState;
    logic    stepData;
    logic    stepTail1;
    logic    stepTail2;
    logic    emit;
    logic    last;
    symSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/rsc_encoder.sv
module rsc_encoder (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic step,
  input  logic tail,
  input  logic uIn,
  output logic dataPar,
  output logic tailSym,
  output logic tailPar
);
  logic s1, s2;
  logic feedBack;
  logic aNext;

  assign feedBack = s1 ^ s2;
  // parity of (u ^ s1 ^ s2) ^ s2 simplifies to u ^ s1
  assign dataPar  = uIn ^ s1;
  // tail input equals feedback, so the register input becomes zero
  assign tailSym  = feedBack;
  assign tailPar  = s2;
  assign aNext    = tail ? 1'b0 : (uIn ^ feedBack);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (clr) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (step) begin
      s1 <= aNext;
      s2 <= s1;
    end
  end
endmodule

// File: rtl/turbo_enc_ctrl.sv
module turbo_enc_ctrl
  import turbo_enc_pkg::*;
#(
  parameter int FRAME_LEN = 45,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             rateHalf,
  output logic             inReady,
  output logic [IDX_W-1:0] idx,
  output ctrlStrobe_t      strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  phase_e     phase;
  logic [1:0] slot;
  logic       tailCnt;
  logic       halfMode;
  logic       p1On, p2On, stepEnd, lastIdx;

  assign lastIdx = (idx == LAST_IDX);
  assign p1On    = !halfMode || idx[0];
  assign p2On    = !halfMode || !idx[0];
  assign stepEnd = (phase == PH_DATA) && ((slot == 2'd2) || (slot == 2'd1 && !p2On));
  assign inReady = (phase == PH_LOAD);

  always_comb begin
    strb          = '0;
    strb.sel      = SEL_SYS;
    strb.wrEn     = (phase == PH_LOAD) && inValid;
    strb.clrState = (phase == PH_LOAD) && inValid && lastIdx;
    unique case (phase)
      PH_DATA: begin
        strb.emit     = 1'b1;
        strb.stepData = stepEnd;
        strb.sel      = (slot == 2'd0) ? SEL_SYS : ((slot == 2'd1) ? SEL_PAR1 : SEL_PAR2);
      end
      PH_TAIL1: begin
        strb.emit      = 1'b1;
        strb.stepTail1 = slot[0];
        strb.sel       = slot[0] ? SEL_TPAR1 : SEL_TSYS1;
      end
      PH_TAIL2: begin
        strb.emit      = 1'b1;
        strb.stepTail2 = slot[0];
        strb.last      = slot[0] && tailCnt;
        strb.sel       = slot[0] ? SEL_TPAR2 : SEL_TSYS2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_LOAD;
      idx      <= '0;
      slot     <= '0;
      tailCnt  <= 1'b0;
      halfMode <= 1'b0;
    end else begin
      unique case (phase)
        PH_LOAD: begin
          if (inValid) begin
            if (lastIdx) begin
              idx      <= '0;
              slot     <= '0;
              halfMode <= rateHalf;
              phase    <= PH_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (stepEnd) begin
            slot <= '0;
            if (lastIdx) begin
              idx     <= '0;
              tailCnt <= 1'b0;
              phase   <= PH_TAIL1;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (slot == 2'd0) begin
            slot <= p1On ? 2'd1 : 2'd2;
          end else begin
            slot <= 2'd2;
          end
        end
        PH_TAIL1, PH_TAIL2: begin
          if (slot[0]) begin
            slot    <= '0;
            tailCnt <= ~tailCnt;
            if (tailCnt) phase <= (phase == PH_TAIL1) ? PH_TAIL2 : PH_LOAD;
          end else begin
            slot <= 2'd1;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/turbo_enc_dp.sv
module turbo_enc_dp
  import turbo_enc_pkg::*;
#(
  parameter int FRAME_LEN = 45,
  parameter int IDX_W     = $clog2(FRAME_LEN),
  parameter int NUM_ENC   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] permAddr,
  input  logic             inBit,
  output logic             outValid,
  output logic             outBit,
  output logic             outLast
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] memBits;
  logic                 uNat, uPerm;
  logic [NUM_ENC-1:0]   uArr, stepArr, tailArr, dataPar, tailSym, tailPar;
  logic                 symNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            memBits <= '0;
    else if (strb.wrEn && idx <= LAST_IDX) memBits[idx] <= inBit;
  end

  assign uNat  = (idx <= LAST_IDX) ? memBits[idx] : 1'b0;
  assign uPerm = (permAddr <= LAST_IDX) ? memBits[permAddr] : 1'b0;

  assign uArr    = {uPerm, uNat};
  assign stepArr = {strb.stepData | strb.stepTail2, strb.stepData | strb.stepTail1};
  assign tailArr = {strb.stepTail2, strb.stepTail1};

  for (genvar e = 0; e < NUM_ENC; e++) begin : g_enc
    rsc_encoder u_rsc (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strb.clrState),
      .step   (stepArr[e]),
      .tail   (tailArr[e]),
      .uIn    (uArr[e]),
      .dataPar(dataPar[e]),
      .tailSym(tailSym[e]),
      .tailPar(tailPar[e])
    );
  end

  always_comb begin
    unique case (strb.sel)
      SEL_SYS:   symNext = uNat;
      SEL_PAR1:  symNext = dataPar[0];
      SEL_PAR2:  symNext = dataPar[1];
      SEL_TSYS1: symNext = tailSym[0];
      SEL_TPAR1: symNext = tailPar[0];
      SEL_TSYS2: symNext = tailSym[1];
      SEL_TPAR2: symNext = tailPar[1];
      default:   symNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strb.emit;
      outBit   <= strb.emit & symNext;
      outLast  <= strb.emit & strb.last;
    end
  end
endmodule

// File: rtl/turbo_punct_enc.sv
module turbo_punct_enc
  import turbo_enc_pkg::*;
#(
  parameter int FRAME_LEN = 45,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inBit,
  input  logic             rateHalf,
  output logic [IDX_W-1:0] ilvAddr,
  input  logic [IDX_W-1:0] ilvPerm,
  output logic             outValid,
  output logic             outBit,
  output logic             outLast
);
  ctrlStrobe_t      strb;
  logic [IDX_W-1:0] idx;

  assign ilvAddr = idx;

  turbo_enc_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .rateHalf(rateHalf),
    .inReady (inReady),
    .idx     (idx),
    .strb    (strb)
  );

  turbo_enc_dp #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .idx     (idx),
    .permAddr(ilvPerm),
    .inBit   (inBit),
    .outValid(outValid),
    .outBit  (outBit),
    .outLast (outLast)
  );
endmodule

// File: rtl/turbo_punct_enc_chk.sv
module turbo_punct_enc_chk #(
  parameter int FRAME_LEN = 45,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [IDX_W-1:0] ilvAddr,
  input logic             outValid,
  input logic             outLast
);
  // R2: input reopens exactly when the last symbol shows
  a_r2_ready_at_last: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> inReady);

  // R2: no symbol during loading except the frame's last one
  a_r2_quiet_while_loading: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !outLast) |-> !outValid);

  // R9: last flag only with a valid symbol
  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R9: nothing follows the last symbol directly
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

  // R10: symbols of a frame are back to back
  a_r10_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  // R4: the natural index never leaves the frame
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    ilvAddr <= IDX_W'(FRAME_LEN - 1));
endmodule

bind turbo_punct_enc turbo_punct_enc_chk #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .ilvAddr (ilvAddr),
  .outValid(outValid),
  .outLast (outLast)
);

// File: tb/turbo_punct_enc_tb_top.sv
`timescale 1ns/1ps
module turbo_punct_enc_tb_top;
  localparam int N     = 45;
  localparam int IDX_W = $clog2(N);
  localparam int NCASE = 6;

  // stimulus table: frame bits (bit i = index i), punctured mode, permutation kind
  localparam logic [N-1:0] DATA_TAB [0:NCASE-1] = '{
    45'h0A5C3F09E27B, 45'h0A5C3F09E27B, {N{1'b1}},
    {N{1'b0}},        45'h100000000000, 45'h0AAAAAAAAAAA };
  localparam logic HALF_TAB [0:NCASE-1] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int   PERM_TAB [0:NCASE-1] = '{1, 1, 0, 2, 1, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inBit = 1'b0, rateHalf = 1'b0;
  logic inReady, outValid, outBit, outLast;
  logic [IDX_W-1:0] ilvAddr, ilvPerm;
  int   permKind = 0;
  int   checks = 0, failures = 0;
  int   cycles = 0;
  bit   done = 1'b0;
  logic expSym [0:199];
  int   expLen;

  always #2 clk = ~clk;

  turbo_punct_enc #(.FRAME_LEN(N)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBit(inBit),
    .rateHalf(rateHalf), .ilvAddr(ilvAddr), .ilvPerm(ilvPerm),
    .outValid(outValid), .outBit(outBit), .outLast(outLast));

  function automatic int permOf(input int i, input int kind);
    if (kind == 1) return (i % 5) * 9 + (i / 5);  // 5 rows x 9 columns, column read
    if (kind == 2) return N - 1 - i;
    return i;
  endfunction

  assign ilvPerm = IDX_W'(permOf(int'(ilvAddr), permKind));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic v);
    expSym[expLen] = v;
    expLen++;
  endtask

  // independent model of R3, R5, R6, R8
  task automatic buildExpected(input logic [N-1:0] d, input logic half, input int kind);
    logic s1a, s2a, s1b, s2b, ua, ub, aa, ab, fb;
    s1a = 0; s2a = 0; s1b = 0; s2b = 0;
    expLen = 0;
    for (int i = 0; i < N; i++) begin
      ua = d[i];
      ub = d[permOf(i, kind)];
      aa = ua ^ s1a ^ s2a;
      ab = ub ^ s1b ^ s2b;
      push(ua);
      if (!half || (i % 2 == 1)) push(aa ^ s2a);
      if (!half || (i % 2 == 0)) push(ab ^ s2b);
      s2a = s1a; s1a = aa;
      s2b = s1b; s1b = ab;
    end
    for (int t = 0; t < 2; t++) begin
      fb = s1a ^ s2a;
      aa = fb ^ s1a ^ s2a;
      push(fb); push(aa ^ s2a);
      s2a = s1a; s1a = aa;
    end
    for (int t = 0; t < 2; t++) begin
      fb = s1b ^ s2b;
      ab = fb ^ s1b ^ s2b;
      push(fb); push(ab ^ s2b);
      s2b = s1b; s1b = ab;
    end
  endtask

  task automatic runFrame(input int c, input bit poke, input bit flipMode);
    int  got;
    int  gaps;
    bit  seenLast;
    buildExpected(DATA_TAB[c], HALF_TAB[c], PERM_TAB[c]);
    permKind = PERM_TAB[c];
    for (int b = 0; b < N; b++) begin
      @(negedge clk);
      if (b == 0) check(inReady == 1'b1, "R2 ready before load", int'(inReady), 1);
      inValid  = 1'b1;
      inBit    = DATA_TAB[c][b];
      rateHalf = HALF_TAB[c];
    end
    @(negedge clk);
    inValid  = poke;          // R11: offered bits while encoding
    inBit    = 1'b1;
    rateHalf = flipMode ? ~HALF_TAB[c] : HALF_TAB[c];  // R7
    check(inReady == 1'b0, "R2 closed after last bit", int'(inReady), 0);
    check(outValid == 1'b0, "R10 no symbol one edge after load", int'(outValid), 0);
    got = 0; gaps = 0; seenLast = 0;
    for (int k = 0; k < 300 && !seenLast; k++) begin
      @(negedge clk);
      if (k == 0) check(outValid == 1'b1, "R10 first symbol latency", int'(outValid), 1);
      if (outValid) begin
        if (got < expLen) begin
          check(outBit == expSym[got], $sformatf("R5 R6 R8 case %0d symbol %0d", c, got),
                int'(outBit), int'(expSym[got]));
          check(outLast == (got == expLen - 1), $sformatf("R9 last flag symbol %0d", got),
                int'(outLast), int'(got == expLen - 1));
        end
        got++;
        if (outLast) begin
          seenLast = 1;
          inValid = 1'b0;
          check(inReady == 1'b1, "R2 reopen at last", int'(inReady), 1);
        end
      end else if (got > 0) begin
        gaps++;
      end
    end
    inValid = 1'b0;
    check(got == expLen, $sformatf("R9 symbol count case %0d", c), got, expLen);
    check(gaps == 0, "R10 no gaps", gaps, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R9 idle after last", int'(outValid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(inReady == 1'b1, "R1 reset inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(outLast == 1'b0, "R1 reset outLast", int'(outLast), 0);
    rstN = 1'b1;

    // main table: R3 R4 R5 R6 R8 R9 R10
    for (int c = 0; c < NCASE; c++) runFrame(c, 1'b0, 1'b0);

    // R11 and R7: poke input and flip mode while encoding
    runFrame(0, 1'b1, 1'b1);
    runFrame(1, 1'b1, 1'b1);

    // R1: reset in the middle of loading, then a clean frame
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      inValid = 1'b1;
      inBit   = 1'b1;
    end
    @(negedge clk);
    inValid = 1'b0;
    rstN    = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R1 mid-load reset inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R1 mid-load reset outValid", int'(outValid), 0);
    rstN = 1'b1;
    runFrame(4, 1'b0, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule